// File: doc/BRIEF.md
# Prescaled 64-bit Compare Timer

This block is a machine timer for a single hart. It has one 64-bit time counter and one 64-bit comparator, and software drives it through a 32-bit register port. While the block is running, a 12-bit prescaler divides the clock. Each time the prescaler wraps, an 8-bit step value is added to the counter. So the counter gains `step` once every `prescale + 1` clock cycles.

The block has two interrupt outputs. The raw timer line is high whenever the timer is running and the counter has reached or passed the compare value. The gated peripheral line comes from a sticky status bit, and that bit is masked by an enable bit. The status bit is set by a compare event or by a software test write, and only while the enable bit is 1. Software clears it by writing 1 to it.

Software starts and stops the timer with bit 0 of the control register. A small run/halt state machine, clocked by the same clock, follows that bit. It has two states:
- `ST_HALT`: the prescaler and the counter hold.
- `ST_RUN`: the prescaler counts.

It has two transitions:
- `go`: from `ST_HALT` to `ST_RUN`, taken while the enable bit is set.
- `stop`: from `ST_RUN` to `ST_HALT`, taken while the enable bit is clear.

Each transition takes effect one cycle after the control bit changes. The start and the stop are delayed by the same amount, so the number of counting cycles equals the number of cycles the control bit was set. All registers use one clock and a synchronous active-low reset.

Top module: `prescaled_cmp_timer`

## Requirements
- R1: After reset, registers read as follows:
  - control 0x000 reads 0;
  - config 0x100 reads 0x00010000;
  - both compare words 0x10C and 0x110 read 0xFFFFFFFF;
  - counter words 0x104 and 0x108 read 0;
  - enable 0x114 and status 0x118 read 0;
  - both interrupt outputs are low.
- R2: While the timer runs, the 64-bit counter gains `step` once every `prescale + 1` cycles. The number of counting cycles equals the number of cycles that control bit 0 was 1. A write to the config register restarts the prescaler from 0.
- R3: The config register at 0x100 holds `prescale` in bits 11:0 and `step` in bits 23:16. All other bits read 0.
- R4: While control bit 0 is clear, the counter holds its value.
- R5: A write to 0x104 loads the low 32 bits of the counter, and a write to 0x108 loads the high 32 bits. When counting overflows the low word, the carry goes into the high word.
- R6: The raw line `raw_tmr_irq` is high exactly when control bit 0 is 1 and compare ≤ counter. This does not depend on the enable bit. The line is low while compare is in the future or the timer is stopped. A compare value already passed fires as soon as the timer runs.
- R7: The raw line first rises in the cycle in which the counter equals the compare value, not one step later.
- R8: A compare event sets status bit 0 (0x118) only when enable bit 0 (0x114) is 1. `tmr_irq` equals status AND enable.
- R9: The status bit is sticky. Writing 1 to bit 0 of 0x118 clears it, and writing 0 has no effect.
- R10: The register at 0x11C is write-only and always reads 0. Writing 1 to its bit 0 sets the status bit only while the enable bit is 1.
- R11: An access to an unmapped or non-word-aligned offset within the 0x400-byte window behaves as follows:
  - a read returns 0;
  - a write changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_addr | input | 10 | Byte offset within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when no read is active |
| raw_tmr_irq | output | 1 | Raw machine-timer interrupt (compare event) |
| tmr_irq | output | 1 | Gated peripheral interrupt (status AND enable) |

## Verification
The bench runs the timer for an exact number of cycles at several prescale and step settings. A design whose prescaler wrapped at `prescale` instead of `prescale + 1`, or whose start and stop delays were unequal, would end with a wrong count. A run from 0xFFFFFFFE across the 32-bit boundary exposes a carry that fails to reach the high word. The raw line is sampled one cycle before and exactly at the counter-equals-compare cycle, which catches a strict less-than comparison. The remaining tests check the interrupt path:
- they set the status bit with the enable bit clear, by a compare event and by a test write;
- they clear it by writing 0 and then 1;
- they read the test register;
- they poke misaligned and unmapped offsets.

A design that ignored the enable mask, cleared on any write, or decoded only part of the address would show wrong register or output values.

// File: rtl/pct_pkg.sv
package pct_pkg;
    localparam int WORD_W   = 32;
    localparam int CNT_W    = 64;
    localparam int PRE_W    = 12;
    localparam int STEP_W   = 8;
    localparam int ADDR_W   = 10;
    localparam int PRE_LSB  = 0;
    localparam int STEP_LSB = 16;

    localparam int OFF_CTRL   = 'h000;
    localparam int OFF_CFG    = 'h100;
    localparam int OFF_CNT_LO = 'h104;
    localparam int OFF_CNT_HI = 'h108;
    localparam int OFF_CMP_LO = 'h10C;
    localparam int OFF_CMP_HI = 'h110;
    localparam int OFF_IEN    = 'h114;
    localparam int OFF_IST    = 'h118;
    localparam int OFF_ITEST  = 'h11C;

    localparam int RESET_STEP = 1;

    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/pct_regs.sv
module pct_regs
    import pct_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int PW  = PRE_W,
    parameter int SW  = STEP_W,
    parameter int CW  = CNT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [AW-1:0]  addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [CW-1:0]  cnt,
    input  logic           ien,
    input  logic           ist,
    output logic [WORD_W-1:0] rdata,
    output logic           active,
    output logic [PW-1:0]  prescale,
    output logic [SW-1:0]  step,
    output logic [CW-1:0]  cmp,
    output logic           cfg_wr,
    output logic           cnt_lo_wr,
    output logic           cnt_hi_wr,
    output logic           ien_wr,
    output logic           ist_wr,
    output logic           itest_wr
);
    localparam int HALF = CW / 2;

    logic ctrl_wr, cmp_lo_wr, cmp_hi_wr;

    // Aligned offsets only; a misaligned address matches nothing.
    always_comb begin
        ctrl_wr   = wr_en && (addr == AW'(OFF_CTRL));
        cfg_wr    = wr_en && (addr == AW'(OFF_CFG));
        cnt_lo_wr = wr_en && (addr == AW'(OFF_CNT_LO));
        cnt_hi_wr = wr_en && (addr == AW'(OFF_CNT_HI));
        cmp_lo_wr = wr_en && (addr == AW'(OFF_CMP_LO));
        cmp_hi_wr = wr_en && (addr == AW'(OFF_CMP_HI));
        ien_wr    = wr_en && (addr == AW'(OFF_IEN));
        ist_wr    = wr_en && (addr == AW'(OFF_IST));
        itest_wr  = wr_en && (addr == AW'(OFF_ITEST));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            prescale <= '0;
            step     <= SW'(RESET_STEP);
            cmp      <= '1;
        end else begin
            if (ctrl_wr)   active <= wdata[0];
            if (cfg_wr) begin
                prescale <= wdata[PRE_LSB +: PW];
                step     <= wdata[STEP_LSB +: SW];
            end
            if (cmp_lo_wr) cmp[HALF-1:0]  <= wdata[HALF-1:0];
            if (cmp_hi_wr) cmp[CW-1:HALF] <= wdata[HALF-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                AW'(OFF_CTRL):   rdata[0] = active;
                AW'(OFF_CFG): begin
                    rdata[PRE_LSB +: PW]  = prescale;
                    rdata[STEP_LSB +: SW] = step;
                end
                AW'(OFF_CNT_LO): rdata = cnt[HALF-1:0];
                AW'(OFF_CNT_HI): rdata = cnt[CW-1:HALF];
                AW'(OFF_CMP_LO): rdata = cmp[HALF-1:0];
                AW'(OFF_CMP_HI): rdata = cmp[CW-1:HALF];
                AW'(OFF_IEN):    rdata[0] = ien;
                AW'(OFF_IST):    rdata[0] = ist;
                default:         rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pct_count.sv
module pct_count
    import pct_pkg::*;
#(
    parameter int PW = PRE_W,
    parameter int SW = STEP_W,
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [PW-1:0]     prescale,
    input  logic [SW-1:0]     step,
    input  logic              cfg_wr,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [CW-1:0]     cnt
);
    localparam int HALF = CW / 2;

    run_state_e state_q, state_d;
    logic [PW-1:0] pcnt_q;
    logic          tick_en, wrap;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (active)  state_d = ST_RUN;   // go
            ST_RUN:  if (!active) state_d = ST_HALT;  // stop
            default: state_d = ST_HALT;
        endcase
    end

    always_comb begin
        tick_en = (state_q == ST_RUN);
        wrap    = tick_en && (pcnt_q == prescale);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       pcnt_q <= '0;
        else if (cfg_wr)  pcnt_q <= '0;
        else if (tick_en) pcnt_q <= wrap ? '0 : pcnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (lo_wr || hi_wr) begin
            if (lo_wr) cnt[HALF-1:0]  <= wdata[HALF-1:0];
            if (hi_wr) cnt[CW-1:HALF] <= wdata[HALF-1:0];
        end else if (wrap) begin
            cnt <= cnt + {{(CW-SW){1'b0}}, step};
        end
    end
endmodule

// File: rtl/pct_irq.sv
module pct_irq
    import pct_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp,
    input  logic          ien_wr,
    input  logic          ist_wr,
    input  logic          itest_wr,
    input  logic          wbit0,
    output logic          raw_irq,
    output logic          irq,
    output logic          ien,
    output logic          ist
);
    logic hit, set_st, clr_st;

    always_comb begin
        hit     = active && (cmp <= cnt);
        raw_irq = hit;
        set_st  = ien && (hit || (itest_wr && wbit0));
        clr_st  = ist_wr && wbit0;
        irq     = ist && ien;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien <= 1'b0;
            ist <= 1'b0;
        end else begin
            if (ien_wr) ien <= wbit0;
            if (set_st)      ist <= 1'b1;
            else if (clr_st) ist <= 1'b0;
        end
    end
endmodule

// File: rtl/prescaled_cmp_timer.sv
module prescaled_cmp_timer
    import pct_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int PW = PRE_W,
    parameter int SW = STEP_W,
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              raw_tmr_irq,
    output logic              tmr_irq
);
    logic          act_q;
    logic [PW-1:0] prescale;
    logic [SW-1:0] step;
    logic [CW-1:0] cmp_q, cnt_q;
    logic          cfg_wr, cnt_lo_wr, cnt_hi_wr, ien_wr, ist_wr, itest_wr;
    logic          ien_q, ist_q;

    pct_regs #(.AW(AW), .PW(PW), .SW(SW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .rd_en(bus_rd),
        .addr(bus_addr), .wdata(bus_wdata), .cnt(cnt_q),
        .ien(ien_q), .ist(ist_q), .rdata(bus_rdata), .active(act_q),
        .prescale(prescale), .step(step), .cmp(cmp_q), .cfg_wr(cfg_wr),
        .cnt_lo_wr(cnt_lo_wr), .cnt_hi_wr(cnt_hi_wr), .ien_wr(ien_wr),
        .ist_wr(ist_wr), .itest_wr(itest_wr)
    );

    pct_count #(.PW(PW), .SW(SW), .CW(CW)) u_count (
        .clk(clk), .rst_n(rst_n), .active(act_q), .prescale(prescale),
        .step(step), .cfg_wr(cfg_wr), .lo_wr(cnt_lo_wr), .hi_wr(cnt_hi_wr),
        .wdata(bus_wdata), .cnt(cnt_q)
    );

    pct_irq #(.CW(CW)) u_irq (
        .clk(clk), .rst_n(rst_n), .active(act_q), .cnt(cnt_q), .cmp(cmp_q),
        .ien_wr(ien_wr), .ist_wr(ist_wr), .itest_wr(itest_wr),
        .wbit0(bus_wdata[0]), .raw_irq(raw_tmr_irq), .irq(tmr_irq),
        .ien(ien_q), .ist(ist_q)
    );
endmodule

// File: rtl/pct_checker.sv
module pct_checker
    import pct_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CNT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [AW-1:0]     addr,
    input logic [WORD_W-1:0] wdata,
    input logic [WORD_W-1:0] rdata,
    input logic              raw_irq,
    input logic              irq,
    input logic              active,
    input logic              ien,
    input logic              ist,
    input logic [CW-1:0]     cnt
);
    logic cnt_write, ist_clear;
    always_comb begin
        cnt_write = wr_en && (addr == AW'(OFF_CNT_LO) || addr == AW'(OFF_CNT_HI));
        ist_clear = wr_en && (addr == AW'(OFF_IST)) && wdata[0];
    end

    // R4
    counter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !$past(active) && !cnt_write) |=> $stable(cnt));

    // R6
    raw_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raw_irq |-> active);

    // R8
    status_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ist) |-> $past(ien));

    // R8
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ist && ien));

    // R9
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ist && !ist_clear) |=> ist);

    // R10
    test_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == AW'(OFF_ITEST)) |-> (rdata == '0));

    // R11
    misaligned_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[1:0] != 2'b00) |-> (rdata == '0));
endmodule

bind prescaled_cmp_timer pct_checker #(.AW(AW), .CW(CW)) u_pct_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .rd_en(bus_rd),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .raw_irq(raw_tmr_irq), .irq(tmr_irq), .active(act_q),
    .ien(ien_q), .ist(ist_q), .cnt(cnt_q)
);

// File: tb/prescaled_cmp_timer_bench.sv
`timescale 1ns/1ps
module prescaled_cmp_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        raw_tmr_irq, tmr_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    prescaled_cmp_timer u_prescaled_cmp_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .raw_tmr_irq(raw_tmr_irq), .tmr_irq(tmr_irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start just after a falling edge and end at the next one.
    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input logic [9:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, {32'h0, d}, {32'h0, exp});
    endtask

    task automatic port_chk(input string req, input logic act, input logic exp);
        #1 chk(req, {63'h0, act}, {63'h0, exp});
    endtask

    task automatic stop_timer();
        wr(10'h000, 32'h0);
        idle(1);
    endtask

    task automatic load_cnt(input logic [63:0] v);
        wr(10'h104, v[31:0]);
        wr(10'h108, v[63:32]);
    endtask

    // Run for exactly n counting cycles (n >= 1), then halt.
    task automatic run_cycles(input int n);
        wr(10'h000, 32'h1);
        idle(n - 1);
        stop_timer();
    endtask

    task automatic t_reset();
        rd_chk("R1 ctrl", 10'h000, 32'h0);
        rd_chk("R1 cfg", 10'h100, 32'h0001_0000);
        rd_chk("R1 cmp lo", 10'h10C, 32'hFFFF_FFFF);
        rd_chk("R1 cmp hi", 10'h110, 32'hFFFF_FFFF);
        rd_chk("R1 cnt lo", 10'h104, 32'h0);
        rd_chk("R1 cnt hi", 10'h108, 32'h0);
        rd_chk("R1 ien", 10'h114, 32'h0);
        rd_chk("R1 ist", 10'h118, 32'h0);
        port_chk("R1 raw", raw_tmr_irq, 1'b0);
        port_chk("R1 irq", tmr_irq, 1'b0);
    endtask

    task automatic t_count_basic();
        load_cnt(64'h0);
        run_cycles(10);
        rd_chk("R2 step1 pre0 lo", 10'h104, 32'd10);
        rd_chk("R2 step1 pre0 hi", 10'h108, 32'd0);
    endtask

    task automatic t_prescale_step();
        wr(10'h100, 32'hFFA5_F003);   // step 0xA5, prescale 3, junk elsewhere
        rd_chk("R3 cfg fields", 10'h100, 32'h00A5_0003);
        wr(10'h100, (32'd5 << 16) | 32'd3);
        load_cnt(64'd1000);
        run_cycles(12);
        rd_chk("R2 step5 pre3", 10'h104, 32'd1015);
        run_cycles(2);                 // prescaler mid-way, no wrap yet
        rd_chk("R2 partial period", 10'h104, 32'd1015);
        wr(10'h100, (32'd5 << 16) | 32'd3); // restart prescaler
        run_cycles(4);
        rd_chk("R2 cfg write restarts prescaler", 10'h104, 32'd1020);
    endtask

    task automatic t_hold();
        idle(5);
        rd_chk("R4 hold while stopped", 10'h104, 32'd1020);
    endtask

    task automatic t_carry();
        wr(10'h100, 32'h0001_0000);
        load_cnt(64'h0000_0000_FFFF_FFFE);
        run_cycles(3);
        rd_chk("R5 carry lo", 10'h104, 32'h1);
        rd_chk("R5 carry hi", 10'h108, 32'h1);
        load_cnt(64'h1234_5678_9ABC_DEF0);
        rd_chk("R5 load lo", 10'h104, 32'h9ABC_DEF0);
        rd_chk("R5 load hi", 10'h108, 32'h1234_5678);
    endtask

    task automatic t_compare_past();
        load_cnt(64'd100);
        wr(10'h10C, 32'd50);
        wr(10'h110, 32'd0);
        port_chk("R6 inactive no event", raw_tmr_irq, 1'b0);
        wr(10'h000, 32'h1);
        port_chk("R6 past compare fires", raw_tmr_irq, 1'b1);
        idle(2);
        rd_chk("R8 no status without enable", 10'h118, 32'h0);
        port_chk("R8 irq low without enable", tmr_irq, 1'b0);
        wr(10'h114, 32'h1);
        idle(1);
        port_chk("R8 irq after enable", tmr_irq, 1'b1);
        stop_timer();
        port_chk("R6 raw low when stopped", raw_tmr_irq, 1'b0);
        wr(10'h110, 32'hFFFF_FFFF);
        wr(10'h118, 32'h0);
        rd_chk("R9 write 0 keeps status", 10'h118, 32'h1);
        wr(10'h118, 32'h1);
        rd_chk("R9 write 1 clears", 10'h118, 32'h0);
        port_chk("R9 irq low after clear", tmr_irq, 1'b0);
    endtask

    task automatic t_compare_equal();
        load_cnt(64'd0);
        wr(10'h10C, 32'd20);
        wr(10'h110, 32'd0);
        wr(10'h000, 32'h1);
        idle(20);                      // counter now 19
        port_chk("R6 future compare low", raw_tmr_irq, 1'b0);
        idle(1);                       // counter now 20
        port_chk("R7 fires at equality", raw_tmr_irq, 1'b1);
        idle(1);
        port_chk("R8 irq on compare", tmr_irq, 1'b1);
        stop_timer();
        wr(10'h110, 32'hFFFF_FFFF);
        wr(10'h118, 32'h1);
        rd_chk("R9 cleared after event", 10'h118, 32'h0);
    endtask

    task automatic t_test_reg();
        wr(10'h114, 32'h0);
        wr(10'h11C, 32'h1);
        rd_chk("R10 test ignored when disabled", 10'h118, 32'h0);
        wr(10'h114, 32'h1);
        wr(10'h11C, 32'h0);
        rd_chk("R10 test write 0 no effect", 10'h118, 32'h0);
        wr(10'h11C, 32'h1);
        rd_chk("R10 test sets status", 10'h118, 32'h1);
        port_chk("R10 irq from test", tmr_irq, 1'b1);
        rd_chk("R10 test reads 0", 10'h11C, 32'h0);
        wr(10'h114, 32'h0);
        port_chk("R8 irq masked by enable", tmr_irq, 1'b0);
        rd_chk("R8 status kept when masked", 10'h118, 32'h1);
        wr(10'h118, 32'h1);
    endtask

    task automatic t_unmapped();
        wr(10'h101, 32'h0);            // misaligned config
        wr(10'h200, 32'hFFFF_FFFF);    // unmapped
        wr(10'h001, 32'h1);            // misaligned control
        rd_chk("R11 misaligned write ignored", 10'h100, 32'h0001_0000);
        rd_chk("R11 ctrl untouched", 10'h000, 32'h0);
        rd_chk("R11 unmapped read", 10'h200, 32'h0);
        rd_chk("R11 misaligned read", 10'h105, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count_basic();
        t_prescale_step();
        t_hold();
        t_carry();
        t_compare_past();
        t_compare_equal();
        t_test_reg();
        t_unmapped();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule